// File: doc/BRIEF.md
# Gate Command Feedback Mismatch Detector

This block watches six conditioned gate commands for a power stage and checks that the driver of each switch answers every command change. Each command has an acknowledgement line that comes back from its driver. A rising or falling edge on a command opens a response window for that channel. The acknowledgement, after a two-stage synchronizer, must reach the new command level before the window closes. If it does not, the block sets that channel's fault bit. The bit stays set until the user clear input is applied. One registered line, the OR of all channel faults, reports to the microcontroller.

Lines that were tri-stated, or that were still settling while the device came out of clear, can show glitches that look like command edges. To keep these from causing false trips, the block ignores command edges for a fixed number of cycles after reset release. It also ignores them whenever the enable input is low, and any open window is dropped while enable is low.

Top module: `gate_fb_monitor`

## Requirements
- R1: While `rst_n` is low, `fault_o` is all zero and `err_o` is 0.
- R2: A change of `cmd_i[k]` between two rising clock edges, when not blanked, starts a check for channel k. The check expects `fb_i[k]` to equal the new command level.
- R3: Let posedge n be the first edge at which the new command level is sampled. If `fb_i[k]` shows the new level at any edge from n+1 through n+TIMEOUT-2, no fault is raised. If it does not, `fault_o[k]` reads 1 right after edge n+TIMEOUT and not before. The window is TIMEOUT cycles on the synchronized feedback, which lags the raw input by two cycles.
- R4: A further command edge on a channel while its check is open restarts the window from the new edge, with the new level as the target.
- R5: A set fault bit stays 1 until an edge at which `fault_clr` is 1. That edge clears it.
- R6: If a channel's timeout and `fault_clr` fall on the same edge, the fault bit is set.
- R7: `err_o` equals the OR of `fault_o` as it stood one cycle earlier.
- R8: Command edges sampled at the first BLANK_CYCLES edges after reset release start no check.
- R9: While `enable` is low, command edges start no check, open checks are dropped, and no fault bit goes from 0 to 1.
- R10: Channels are independent. A timeout on one channel changes no other channel's fault bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| fault_clr | input | 1 | User fault clear, sampled per edge, active high |
| enable | input | 1 | Checking enable. Low blanks edge detection |
| cmd_i | input | NUM_CH | Conditioned gate commands |
| fb_i | input | NUM_CH | Driver acknowledgements, asynchronous |
| err_o | output | 1 | Registered OR of all channel faults |
| fault_o | output | NUM_CH | Latched per-channel fault bits |

## Verification
Raw feedback takes two edges to reach the comparator. A missing acknowledgement therefore shows on `fault_o` right after edge n+TIMEOUT, and on `err_o` one edge later. Feedback sampled at edge n+TIMEOUT-2 is the last that counts as in time. The bench drives inputs one nanosecond after a rising edge and samples one nanosecond after the next. Directed cases look at the exact cycles on either side of each deadline. A deadline-based reference model, stepped on the same edges, is compared with both outputs on every cycle of the random phase.

// File: rtl/gfm_pkg.sv
`timescale 1ns/1ps
package gfm_pkg;
    // Per-channel watch state
    typedef enum logic {
        WATCH_IDLE = 1'b0,
        WATCH_OPEN = 1'b1
    } watch_state_e;

    // Counter width that can hold values 0..n-1 (at least one bit)
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/gfm_sync.sv
`timescale 1ns/1ps
module gfm_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/gfm_blanker.sv
`timescale 1ns/1ps
module gfm_blanker #(
    parameter int unsigned BLANK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic blank
);
    localparam int unsigned HW = gfm_pkg::span_bits(BLANK_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_INIT = HW'(BLANK_CYCLES);

    typedef struct packed {
        logic [HW-1:0] hold;
    } blank_state_t;

    blank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hold != '0) st_d.hold = st_q.hold - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.hold <= HOLD_INIT;
        else        st_q      <= st_d;
    end

    assign blank = (st_q.hold != '0) | ~enable;
endmodule

// File: rtl/gfm_channel.sv
`timescale 1ns/1ps
module gfm_channel #(
    parameter int unsigned TIMEOUT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blank,
    input  logic cmd,
    input  logic fb_sync,
    input  logic clr,
    output logic fault
);
    import gfm_pkg::*;

    localparam int unsigned    CW   = span_bits(TIMEOUT);
    localparam logic [CW-1:0]  LAST = CW'(TIMEOUT - 1);

    typedef struct packed {
        logic          prev;
        watch_state_e  state;
        logic          target;
        logic [CW-1:0] cnt;
        logic          fault;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        cmd_edge;
    logic        trip;

    always_comb begin
        st_d     = st_q;
        trip     = 1'b0;
        cmd_edge = cmd ^ st_q.prev;
        st_d.prev = cmd;

        if (blank) begin
            st_d.state = WATCH_IDLE;
            st_d.cnt   = '0;
        end else if (cmd_edge) begin
            st_d.state  = WATCH_OPEN;
            st_d.target = cmd;
            st_d.cnt    = '0;
        end else if (st_q.state == WATCH_OPEN) begin
            if (fb_sync == st_q.target) begin
                st_d.state = WATCH_IDLE;
            end else if (st_q.cnt == LAST) begin
                trip       = 1'b1;
                st_d.state = WATCH_IDLE;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // new trip wins over a simultaneous clear
        st_d.fault = trip | (st_q.fault & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev   <= 1'b0;
            st_q.state  <= WATCH_IDLE;
            st_q.target <= 1'b0;
            st_q.cnt    <= '0;
            st_q.fault  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.fault;
endmodule

// File: rtl/gate_fb_monitor.sv
`timescale 1ns/1ps
module gate_fb_monitor #(
    parameter int unsigned NUM_CH       = 6,
    parameter int unsigned TIMEOUT      = 200,
    parameter int unsigned BLANK_CYCLES = 16,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_clr,
    input  logic              enable,
    input  logic [NUM_CH-1:0] cmd_i,
    input  logic [NUM_CH-1:0] fb_i,
    output logic              err_o,
    output logic [NUM_CH-1:0] fault_o
);
    typedef struct packed {
        logic err;
    } top_state_t;

    logic [NUM_CH-1:0] fb_sync;
    logic              blank;
    top_state_t        st_d, st_q;

    gfm_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (fb_i),
        .dout (fb_sync)
    );

    gfm_blanker #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .blank (blank)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        gfm_channel #(.TIMEOUT(TIMEOUT)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .blank  (blank),
            .cmd    (cmd_i[k]),
            .fb_sync(fb_sync[k]),
            .clr    (fault_clr),
            .fault  (fault_o[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = |fault_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.err <= 1'b0;
        else        st_q     <= st_d;
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/gfm_checker.sv
`timescale 1ns/1ps
module gfm_checker #(
    parameter int unsigned NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              fault_clr,
    input logic [NUM_CH-1:0] fault_o,
    input logic              err_o
);
    // R1: outputs quiet while held in clear
    always @(negedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (fault_o == '0 && !err_o);
        end
    end

    // R7: combined line follows the fault bits one cycle later
    p_err_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == $past(|fault_o));

    // R9: no fault bit rises on an edge where checking was disabled
    p_no_rise_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((fault_o & ~$past(fault_o)) == '0));

    // R5: latched until clear
    for (genvar k = 0; k < NUM_CH; k++) begin : g_latch
        p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_o[k] && !fault_clr) |=> fault_o[k]);
    end
endmodule

bind gate_fb_monitor gfm_checker #(.NUM_CH(NUM_CH)) u_gfm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .fault_clr(fault_clr),
    .fault_o  (fault_o),
    .err_o    (err_o)
);

// File: tb/sim_gate_fb_monitor.sv
`timescale 1ns/1ps
module sim_gate_fb_monitor;
    localparam int NCH = 6;
    localparam int T   = 200;
    localparam int BL  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clr = 1'b0;
    logic           en = 1'b0;
    logic [NCH-1:0] cmd = '0;
    logic [NCH-1:0] fb = '0;
    logic           err_o;
    logic [NCH-1:0] fault_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gate_fb_monitor #(.NUM_CH(NCH), .TIMEOUT(T), .BLANK_CYCLES(BL), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .fault_clr(clr), .enable(en),
        .cmd_i(cmd), .fb_i(fb), .err_o(err_o), .fault_o(fault_o)
    );

    // ---------- deadline-based reference model ----------
    logic [NCH-1:0] m_h1, m_h2, m_prev, m_pend, m_tgt, m_fault;
    logic           m_err;
    int             m_dl [NCH];
    int             m_bc;
    int             cyc;
    bit             m_blank;
    bit             m_set;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_h1 <= '0; m_h2 <= '0; m_prev <= '0; m_pend <= '0;
            m_tgt <= '0; m_fault <= '0; m_err <= 1'b0; m_bc <= BL; cyc <= 0;
            for (int i = 0; i < NCH; i++) m_dl[i] <= 0;
        end else begin
            m_blank = (m_bc != 0) || !en;
            cyc    <= cyc + 1;
            m_h1   <= fb;
            m_h2   <= m_h1;
            m_prev <= cmd;
            m_err  <= |m_fault;
            if (m_bc > 0) m_bc <= m_bc - 1;
            for (int i = 0; i < NCH; i++) begin
                m_set = 1'b0;
                if (m_blank) begin
                    m_pend[i] <= 1'b0;
                end else if (cmd[i] != m_prev[i]) begin
                    m_pend[i] <= 1'b1;
                    m_tgt[i]  <= cmd[i];
                    m_dl[i]   <= cyc + T;
                end else if (m_pend[i]) begin
                    if (m_h2[i] == m_tgt[i]) m_pend[i] <= 1'b0;
                    else if (cyc == m_dl[i]) begin
                        m_pend[i] <= 1'b0;
                        m_set = 1'b1;
                    end
                end
                m_fault[i] <= m_set | (m_fault[i] & ~clr);
            end
        end
    end

    // ---------- check helpers ----------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // one clock: advance to just after the edge, then compare with the model
    task automatic cycle();
        @(posedge clk);
        #1;
        check(fault_o == m_fault, "R3 model fault_o", fault_o, m_fault);
        check(err_o == m_err, "R7 model err_o", err_o, m_err);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic clear_all();
        fb = cmd;
        cycles(4);
        clr = 1'b1;
        cycle();
        clr = 1'b0;
        cycle();
        check(fault_o == '0, "R5 cleared", fault_o, 0);
    endtask

    // ---------- watchdog ----------
    initial begin
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------- stimulus ----------
    int fbw [NCH];

    initial begin
        void'($urandom(32'd2718));
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check(fault_o == '0, "R1 fault_o in reset", fault_o, 0);
        check(err_o == 1'b0, "R1 err_o in reset", err_o, 0);
        rst_n = 1'b1;
        en    = 1'b1;

        // R8: edge inside blanking window, no feedback ever
        cycle();
        cmd[1] = 1'b1;
        cycles(T + 20);
        check(fault_o[1] == 1'b0, "R8 edge during blank ignored", fault_o[1], 0);
        fb[1] = 1'b1;
        cycles(4);

        // R3 / R2: feedback sampled at edge n+T-2 is in time
        cmd[0] = 1'b1;
        cycle();                // edge n
        cycles(T - 3);          // now after n+T-3
        fb[0] = 1'b1;           // sampled at n+T-2
        cycles(10);
        check(fault_o[0] == 1'b0, "R3 feedback on last in-time edge", fault_o[0], 0);

        // R3 / R7 / R10: feedback one edge late
        cmd[0] = 1'b0;
        cycle();                // edge n
        cycles(T - 2);          // after n+T-2
        fb[0] = 1'b0;           // sampled at n+T-1: late
        cycle();                // after n+T-1
        check(fault_o[0] == 1'b0, "R3 no fault before deadline", fault_o[0], 0);
        cycle();                // after n+T
        check(fault_o == 6'b000001, "R3 R10 fault on deadline, only ch0", fault_o, 6'b000001);
        check(err_o == 1'b0, "R7 err lags one cycle", err_o, 0);
        cycle();
        check(err_o == 1'b1, "R7 err follows fault", err_o, 1);

        // R5 latch
        cycles(30);
        check(fault_o[0] == 1'b1, "R5 fault stays latched", fault_o[0], 1);

        // R6: timeout on ch2 coincides with clear
        cmd[2] = 1'b1;
        cycle();                // edge n
        cycles(T - 1);          // after n+T-1
        check(fault_o[2] == 1'b0, "R6 ch2 not yet tripped", fault_o[2], 0);
        clr = 1'b1;
        cycle();                // edge n+T with clear
        clr = 1'b0;
        check(fault_o[2] == 1'b1, "R6 trip wins over clear", fault_o[2], 1);
        check(fault_o[0] == 1'b0, "R5 clear removes old fault", fault_o[0], 0);
        clear_all();

        // R4: re-edge restarts window (no feedback at all)
        cmd[3] = 1'b1;
        cycle();                // edge n
        cycles(T / 2 - 1);
        cmd[3] = 1'b0;
        cycle();
        cmd[3] = 1'b1;
        cycle();                // new edge at n+T/2+1
        cycles(T / 2 + 3);      // past old deadline n+T
        check(fault_o[3] == 1'b0, "R4 old deadline dropped", fault_o[3], 0);
        cycles(T / 2);
        check(fault_o[3] == 1'b1, "R4 restarted window expires", fault_o[3], 1);
        clear_all();

        // R9: disabled edges ignored
        en = 1'b0;
        cycle();
        cmd[4] = 1'b1;
        cycles(T + 10);
        check(fault_o[4] == 1'b0, "R9 edge while disabled ignored", fault_o[4], 0);
        en = 1'b1;
        fb[4] = 1'b1;
        cycles(4);
        // R9: open check dropped when enable falls
        cmd[5] = 1'b1;
        cycles(6);
        en = 1'b0;
        cycles(3);
        en = 1'b1;
        cycles(T + 10);
        check(fault_o[5] == 1'b0, "R9 open check dropped", fault_o[5], 0);
        check(err_o == 1'b0, "R7 err quiet", err_o, 0);
        clear_all();

        // ---------- random phase, model compared every cycle ----------
        for (int i = 0; i < NCH; i++) fbw[i] = 0;
        for (int c = 0; c < 40000; c++) begin
            for (int i = 0; i < NCH; i++) begin
                if (fbw[i] == 1) fb[i] = cmd[i];
                if (fbw[i] > 0) fbw[i]--;
                if (fbw[i] == 0 && ($urandom % 80) == 0) begin
                    int r;
                    cmd[i] = ~cmd[i];
                    r = $urandom % 16;
                    if (r == 0)      fbw[i] = -1;
                    else if (r < 3)  fbw[i] = T - 3 + int'($urandom % 4);
                    else             fbw[i] = 1 + int'($urandom % (T - 5));
                end
                if (fbw[i] < 0 && ($urandom % 400) == 0) fbw[i] = 1;
                if (($urandom % 3000) == 0) fb[i] = ~fb[i];
            end
            clr = (($urandom % 150) == 0);
            if (($urandom % 2000) == 0) en = 1'b0;
            else if (($urandom % 20) == 0) en = 1'b1;
            cycle();
        end
        clr = 1'b0;
        en  = 1'b1;
        cycles(5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule